// File: doc/BRIEF.md
# Staged-Store Dual-Width Data Memory

This block is a small data memory organised as 256-bit rows. A requester presents a byte address together with a width qualifier and a direction qualifier. A wide access moves a whole row. A narrow access moves one 32-bit lane of a row. Every access is checked for alignment and range before it takes effect. A rejected access gets a response with zero data and a single error flag.

Stores do not reach the storage when they are issued. Each legal store is recorded in a small pending queue. A commit pulse drains the queue into the rows one entry per cycle, in issue order. An abort pulse empties the queue and leaves the rows as they were. Loads always see committed contents only. This gives a compute engine a way to run a stretch of work speculatively, then either keep or drop every memory write that stretch made.

Top module: `stagemem_top`

## Requirements
- R1: After reset every row holds 0xDEADBEEF in each of its eight 32-bit lanes, `busy` is low and `rsp_valid` is low.
- R2: A wide access whose address has any of bits [4:0] set gets `rsp_err_align`, zero `rsp_rdata`, and nothing is recorded.
- R3: A narrow access whose address has any of bits [1:0] set gets `rsp_err_align`, zero `rsp_rdata`, and nothing is recorded.
- R4: An aligned access gets `rsp_err_range` when its row index, taken as (address + 3) / 32 for narrow and address / 32 for wide, is at least ROWS. At most one error flag is high in a response, and an alignment error takes precedence over a range error.
- R5: Lanes are little-endian: row = address / 32, lane = address bits [4:2], and lane k occupies row bits [32k+31:32k]. A narrow load returns its lane in `rsp_rdata[31:0]` with bits [255:32] zero.
- R6: An accepted request gets exactly one response with `rsp_valid` high in the following cycle. A store response carries zero data. When `rsp_valid` is low, all error flags and `rsp_rdata` are zero.
- R7: A recorded store leaves the rows unchanged until it is committed, so loads in between return the old contents.
- R8: A commit pulse with N pending entries raises `busy` for exactly N cycles and applies the entries in issue order. A wide entry replaces its row. A narrow entry replaces only its lane.
- R9: An abort pulse while not busy discards every pending entry, so a following commit writes nothing and leaves `busy` low.
- R10: A legal store issued while PEND_DEPTH entries are pending gets `rsp_err_full` and is not recorded.
- R11: A request is refused with no response and no effect while `busy` is high, or in a cycle where `commit_i` or `abort_i` is high. Commit and abort pulses are ignored while `busy` is high.
- R12: A commit pulse with an empty queue leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_wide | input | 1 | 1 = 256-bit row access, 0 = 32-bit lane access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 256 | Store data; narrow stores use bits [31:0] |
| commit_i | input | 1 | Pulse: apply pending stores |
| abort_i | input | 1 | Pulse: drop pending stores |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | 256 | Load data, zero for stores and errors |
| rsp_err_align | output | 1 | Misaligned address |
| rsp_err_range | output | 1 | Row index beyond the last row |
| rsp_err_full | output | 1 | Store refused, pending queue full |
| busy | output | 1 | Commit drain in progress |

## Verification
The bench builds the block with ROWS = 4, PEND_DEPTH = 4 and ADDR_W = 12. The four-row memory places the range boundary at byte 128, so both the last legal lane and the first illegal one can be reached with short directed sequences. Four queue slots let a single scenario fill the queue with a mix of wide and narrow stores, including two stores to the same lane and a lane merged over a freshly written row. That same scenario then provokes the overflow and measures a four-cycle drain.

// File: rtl/stagemem_pkg.sv
package stagemem_pkg;
    localparam int ROW_W  = 256;
    localparam int LANE_W = 32;
    localparam int LANES  = ROW_W / LANE_W;
    localparam int LANE_IDX_W = $clog2(LANES);

    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [LANE_W-1:0] lane_t;

    localparam lane_t FILL_WORD = 32'hDEADBEEF;

    typedef enum logic [1:0] {
        CHK_OK    = 2'd0,
        CHK_ALIGN = 2'd1,
        CHK_RANGE = 2'd2,
        CHK_FULL  = 2'd3
    } chk_e;

    function automatic row_t lane_put(row_t r, logic [LANE_IDX_W-1:0] idx, lane_t v);
        row_t o;
        o = r;
        o[{idx, 5'b00000} +: LANE_W] = v;
        return o;
    endfunction

    function automatic lane_t lane_get(row_t r, logic [LANE_IDX_W-1:0] idx);
        return r[{idx, 5'b00000} +: LANE_W];
    endfunction
endpackage

// File: rtl/stagemem_addrchk.sv
module stagemem_addrchk
    import stagemem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int ROWS   = 4,
    parameter int RIDX_W = 2
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wide,
    output chk_e                  verdict,
    output logic [RIDX_W-1:0]     row,
    output logic [LANE_IDX_W-1:0] lane
);
    logic [ADDR_W:0] last_byte;
    logic [ADDR_W:0] last_row;
    logic            misaligned;

    always_comb begin
        last_byte  = {1'b0, addr} + (wide ? (ADDR_W+1)'(0) : (ADDR_W+1)'(3));
        last_row   = last_byte >> 5;
        misaligned = wide ? (|addr[4:0]) : (|addr[1:0]);
        if (misaligned)
            verdict = CHK_ALIGN;
        else if (last_row >= (ADDR_W+1)'(ROWS))
            verdict = CHK_RANGE;
        else
            verdict = CHK_OK;
    end

    assign row  = addr[RIDX_W+4:5];
    assign lane = addr[4:2];
endmodule

// File: rtl/stagemem_pendq.sv
module stagemem_pendq #(
    parameter int DEPTH = 4,
    parameter int ENT_W = 262,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [ENT_W-1:0] push_ent,
    input  logic             pop,
    input  logic             flush,
    output logic [ENT_W-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [ENT_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    logic do_push, do_pop;
    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            if (do_push && !do_pop)
                count <= count + CNT_W'(1);
            else if (do_pop && !do_push)
                count <= count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_ent;
    end

    assign head = slots[rd_ptr];
endmodule

// File: rtl/stagemem_rows.sv
module stagemem_rows
    import stagemem_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int RIDX_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  wr_wide,
    input  logic [RIDX_W-1:0]     wr_row,
    input  logic [LANE_IDX_W-1:0] wr_lane,
    input  row_t                  wr_data,
    input  logic [RIDX_W-1:0]     rd_row,
    output row_t                  rd_data
);
    row_t store [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst)
                store[g] <= {LANES{FILL_WORD}};
            else if (wr_en && wr_row == RIDX_W'(g)) begin
                if (wr_wide)
                    store[g] <= wr_data;
                else
                    store[g] <= lane_put(store[g], wr_lane, wr_data[LANE_W-1:0]);
            end
        end
    end

    assign rd_data = store[rd_row];
endmodule

// File: rtl/stagemem_top.sv
module stagemem_top
    import stagemem_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int ROWS       = 4,
    parameter int PEND_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_wide,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [255:0]      req_wdata,
    input  logic              commit_i,
    input  logic              abort_i,
    output logic              rsp_valid,
    output logic [255:0]      rsp_rdata,
    output logic              rsp_err_align,
    output logic              rsp_err_range,
    output logic              rsp_err_full,
    output logic              busy
);
    localparam int RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int ENT_W  = 1 + RIDX_W + LANE_IDX_W + ROW_W;
    localparam int CNT_W  = $clog2(PEND_DEPTH + 1);

    chk_e                  addr_verdict, verdict;
    logic [RIDX_W-1:0]     req_row;
    logic [LANE_IDX_W-1:0] req_lane;

    stagemem_addrchk #(.ADDR_W(ADDR_W), .ROWS(ROWS), .RIDX_W(RIDX_W)) u_chk_addr (
        .addr    (req_addr),
        .wide    (req_wide),
        .verdict (addr_verdict),
        .row     (req_row),
        .lane    (req_lane)
    );

    logic             draining;
    logic             accept, push, commit_go, abort_go;
    logic [ENT_W-1:0] head;
    logic [CNT_W-1:0] q_count;
    logic             q_full, q_empty;

    assign accept = req_valid && !draining && !commit_i && !abort_i;

    always_comb begin
        verdict = addr_verdict;
        if (addr_verdict == CHK_OK && req_write && q_full)
            verdict = CHK_FULL;
    end

    assign push      = accept && req_write && (verdict == CHK_OK);
    assign commit_go = commit_i && !abort_i && !draining && !q_empty;
    assign abort_go  = abort_i && !draining;

    stagemem_pendq #(.DEPTH(PEND_DEPTH), .ENT_W(ENT_W)) u_pendq (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent ({req_wide, req_row, req_lane, req_wdata}),
        .pop      (draining),
        .flush    (abort_go),
        .head     (head),
        .count    (q_count),
        .full     (q_full),
        .empty    (q_empty)
    );

    always_ff @(posedge clk) begin
        if (rst)
            draining <= 1'b0;
        else if (commit_go)
            draining <= 1'b1;
        else if (draining && q_count == CNT_W'(1))
            draining <= 1'b0;
    end

    logic                  h_wide;
    logic [RIDX_W-1:0]     h_row;
    logic [LANE_IDX_W-1:0] h_lane;
    row_t                  h_data;
    row_t                  rd_row_data;

    assign {h_wide, h_row, h_lane, h_data} = head;

    stagemem_rows #(.ROWS(ROWS), .RIDX_W(RIDX_W)) u_rows (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (draining),
        .wr_wide (h_wide),
        .wr_row  (h_row),
        .wr_lane (h_lane),
        .wr_data (h_data),
        .rd_row  (req_row),
        .rd_data (rd_row_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            rsp_err_align <= 1'b0;
            rsp_err_range <= 1'b0;
            rsp_err_full  <= 1'b0;
        end else begin
            rsp_valid     <= accept;
            rsp_err_align <= accept && (verdict == CHK_ALIGN);
            rsp_err_range <= accept && (verdict == CHK_RANGE);
            rsp_err_full  <= accept && (verdict == CHK_FULL);
            if (accept && !req_write && verdict == CHK_OK)
                rsp_rdata <= req_wide ? rd_row_data
                                      : {{(ROW_W-LANE_W){1'b0}}, lane_get(rd_row_data, req_lane)};
            else
                rsp_rdata <= '0;
        end
    end

    assign busy = draining;
endmodule

// File: rtl/stagemem_sva.sv
module stagemem_sva #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_wide,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              commit_i,
    input logic              abort_i,
    input logic              rsp_valid,
    input logic [255:0]      rsp_rdata,
    input logic              rsp_err_align,
    input logic              rsp_err_range,
    input logic              rsp_err_full,
    input logic              busy
);
    logic taken;
    assign taken = req_valid && !busy && !commit_i && !abort_i;

    AST_RSP_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(taken)); // R11
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> !rsp_valid); // R11
    AST_ONE_ERROR: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_err_align, rsp_err_range, rsp_err_full})); // R4
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_err_align || rsp_err_range || rsp_err_full)) |-> (rsp_rdata == '0)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_err_align && !rsp_err_range && !rsp_err_full && rsp_rdata == '0)); // R6
    AST_WIDE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (taken && req_wide && (|req_addr[4:0])) |=> rsp_err_align); // R2
    AST_NARROW_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (taken && !req_wide && (|req_addr[1:0])) |=> rsp_err_align); // R3
    AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit_i)); // R8
    AST_FULL_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
        rsp_err_full |-> $past(req_write)); // R10
endmodule

bind stagemem_top stagemem_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_wide      (req_wide),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .commit_i      (commit_i),
    .abort_i       (abort_i),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rsp_err_align (rsp_err_align),
    .rsp_err_range (rsp_err_range),
    .rsp_err_full  (rsp_err_full),
    .busy          (busy)
);

// File: tb/sim_stagemem_top.sv
`timescale 1ns/1ps
module sim_stagemem_top;
    localparam int AW = 12;
    localparam logic [255:0] DB = {8{32'hDEADBEEF}};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0, req_wide = 1'b0, req_write = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [255:0]   req_wdata = '0;
    logic           commit_i = 1'b0, abort_i = 1'b0;
    logic           rsp_valid, rsp_err_align, rsp_err_range, rsp_err_full, busy;
    logic [255:0]   rsp_rdata;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stagemem_top #(.ADDR_W(AW), .ROWS(4), .PEND_DEPTH(4)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_wide(req_wide),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .commit_i(commit_i), .abort_i(abort_i), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err_align(rsp_err_align),
        .rsp_err_range(rsp_err_range), .rsp_err_full(rsp_err_full), .busy(busy)
    );

    function automatic logic [255:0] pat(logic [31:0] base);
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[32*i +: 32] = base + 32'(i);
        return r;
    endfunction

    function automatic logic [255:0] put(logic [255:0] r, int l, logic [31:0] v);
        logic [255:0] o;
        o = r;
        o[32*l +: 32] = v;
        return o;
    endfunction

    task automatic ck(input bit ok, input string rq, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // drive one request, sample the response one negedge later
    task automatic req(input bit w, input bit wr, input logic [AW-1:0] a, input logic [255:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_wide = w; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string rq, input logic [255:0] data,
                              input bit ea, input bit er, input bit ef);
        ck(rsp_valid && rsp_rdata == data && rsp_err_align == ea &&
           rsp_err_range == er && rsp_err_full == ef, rq, "response",
           {rsp_valid, rsp_err_align, rsp_err_range, rsp_err_full, rsp_rdata[251:0]},
           {1'b1, ea, er, ef, data[251:0]});
    endtask

    task automatic do_commit(output int n);
        @(negedge clk);
        commit_i = 1'b1;
        @(negedge clk);
        commit_i = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        ck(!busy && !rsp_valid, "R1", "idle after reset", {254'b0, busy, rsp_valid}, '0);
        req(1'b1, 1'b0, 12'h000, '0);
        expect_rsp("R1", DB, 0, 0, 0);
        req(1'b0, 1'b0, 12'h024, '0);
        expect_rsp("R1", {224'b0, 32'hDEADBEEF}, 0, 0, 0);
    endtask

    task automatic t_stage;
        int n;
        req(1'b1, 1'b1, 12'h020, pat(32'hA0000000));
        expect_rsp("R6", '0, 0, 0, 0);
        req(1'b1, 1'b0, 12'h020, '0);
        expect_rsp("R7", DB, 0, 0, 0);
        do_commit(n);
        ck(n == 1, "R8", "busy cycles", 256'(n), 256'd1);
        req(1'b1, 1'b0, 12'h020, '0);
        expect_rsp("R8", pat(32'hA0000000), 0, 0, 0);
    endtask

    task automatic t_order_full;
        int n;
        req(1'b0, 1'b1, 12'h008, 256'h11111111);
        req(1'b0, 1'b1, 12'h008, 256'h22222222);
        req(1'b1, 1'b1, 12'h040, pat(32'hB0000000));
        req(1'b0, 1'b1, 12'h05C, 256'h33333333);
        req(1'b1, 1'b1, 12'h060, pat(32'hC0000000));
        expect_rsp("R10", '0, 0, 0, 1);
        do_commit(n);
        ck(n == 4, "R8", "busy cycles for four entries", 256'(n), 256'd4);
        req(1'b1, 1'b0, 12'h000, '0);
        expect_rsp("R8", put(DB, 2, 32'h22222222), 0, 0, 0);
        req(1'b1, 1'b0, 12'h040, '0);
        expect_rsp("R8", put(pat(32'hB0000000), 7, 32'h33333333), 0, 0, 0);
        req(1'b1, 1'b0, 12'h060, '0);
        expect_rsp("R10", DB, 0, 0, 0);
        req(1'b0, 1'b0, 12'h008, '0);
        expect_rsp("R5", {224'b0, 32'h22222222}, 0, 0, 0);
        req(1'b0, 1'b0, 12'h05C, '0);
        expect_rsp("R5", {224'b0, 32'h33333333}, 0, 0, 0);
    endtask

    task automatic t_abort;
        int n;
        req(1'b1, 1'b1, 12'h060, pat(32'hC0000000));
        @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        do_commit(n);
        ck(n == 0, "R9", "commit after abort", 256'(n), '0);
        req(1'b1, 1'b0, 12'h060, '0);
        expect_rsp("R9", DB, 0, 0, 0);
    endtask

    task automatic t_align;
        int n;
        req(1'b1, 1'b0, 12'h004, '0);
        expect_rsp("R2", '0, 1, 0, 0);
        req(1'b1, 1'b1, 12'h050, pat(32'hEE000000));
        expect_rsp("R2", '0, 1, 0, 0);
        req(1'b0, 1'b1, 12'h006, 256'h99999999);
        expect_rsp("R3", '0, 1, 0, 0);
        req(1'b0, 1'b0, 12'h07D, '0);
        expect_rsp("R3", '0, 1, 0, 0);
        req(1'b1, 1'b0, 12'h090, '0);
        expect_rsp("R4", '0, 1, 0, 0);
        do_commit(n);
        ck(n == 0, "R3", "misaligned stores not recorded", 256'(n), '0);
    endtask

    task automatic t_range;
        int n;
        req(1'b1, 1'b0, 12'h080, '0);
        expect_rsp("R4", '0, 0, 1, 0);
        req(1'b0, 1'b0, 12'h07C, '0);
        expect_rsp("R4", {224'b0, 32'hDEADBEEF}, 0, 0, 0);
        req(1'b0, 1'b0, 12'h080, '0);
        expect_rsp("R4", '0, 0, 1, 0);
        req(1'b0, 1'b1, 12'h084, 256'h77777777);
        expect_rsp("R4", '0, 0, 1, 0);
        do_commit(n);
        ck(n == 0, "R4", "out-of-range store not recorded", 256'(n), '0);
    endtask

    task automatic t_refuse;
        int n;
        req(1'b1, 1'b1, 12'h000, pat(32'hC0000000));
        req(1'b0, 1'b1, 12'h034, 256'h55555555);
        @(negedge clk);
        commit_i = 1'b1;
        @(negedge clk);
        commit_i = 1'b0;
        ck(busy, "R8", "busy after commit", {255'b0, busy}, 256'd1);
        req_valid = 1'b1; req_wide = 1'b1; req_write = 1'b0; req_addr = 12'h000;
        abort_i = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; abort_i = 1'b0;
        ck(!rsp_valid, "R11", "request while busy", {255'b0, rsp_valid}, '0);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        req(1'b1, 1'b0, 12'h000, '0);
        expect_rsp("R11", pat(32'hC0000000), 0, 0, 0);
        req(1'b1, 1'b0, 12'h020, '0);
        expect_rsp("R8", put(pat(32'hA0000000), 5, 32'h55555555), 0, 0, 0);
        // request alongside an empty-queue commit
        @(negedge clk);
        req_valid = 1'b1; req_wide = 1'b1; req_write = 1'b0; req_addr = 12'h000;
        commit_i = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; commit_i = 1'b0;
        ck(!rsp_valid, "R11", "request with commit", {255'b0, rsp_valid}, '0);
        ck(!busy, "R12", "empty commit", {255'b0, busy}, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_stage;
        t_order_full;
        t_abort;
        t_align;
        t_range;
        t_refuse;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule